// File: doc/BRIEF.md
# Reset-Time Debug Mode Selector

This block chooses the run mode of the device from the level of a shared single-wire debug pin at the moment the internal reset is released, and then controls what that pin does. Only a power-on reset or a debug-forced reset lets the pin pick the mode. A pin pulled low at release enters active background mode. A pin left high, which is its idle pulled-up level, gives normal operation. Every other reset leaves the latched mode as it was.

Every reset of any kind hands the pin back to the debug serial engine and forces its pull-up on. Software gets the pin for its general-purpose or comparator-output use by clearing an enable bit once reset has ended. The pin level passes through a synchronizer before it is captured. A forced reset is flagged by a one-cycle request pulse ahead of, or on, the cycle in which reset asserts. The block reports the cause of the most recent reset on an output.

Top module: `dbg_pin_mode_ctl`

## Requirements
- R1: While `rst_n` is low, the outputs are `bkgd_mode`=0, `en_rd`=1, `pin_pullup_en`=1, `pin_func_dbg`=1 and `rst_cause`=1 (power-on).
- R2: The `rst_cause` code is 0 for other, 1 for power-on and 2 for debug-forced. The code is set on the first clock edge that sees `sys_rst_n` low: 1 if `por_cause` is high, else 2 if a `dbg_force_req` pulse arrived outside reset since the previous reset or on that edge, else 0. A `por_cause` high later in the same reset raises the code to 1. A request pulse arriving while reset is asserted is ignored. The code does not change while `sys_rst_n` is high.
- R3: On a release edge (the first edge with `sys_rst_n` high after it was low) following a code-1 or code-2 reset, `bkgd_mode` becomes 1 if the synchronized pin is low and 0 if it is high. It is visible from the next cycle.
- R4: A release following a code-0 reset leaves `bkgd_mode` unchanged, whatever the pin level.
- R5: The pin is captured through a two-stage synchronizer. The level used at a release edge is the one `pin_in` held two edges before it, so a change one cycle before release is not seen.
- R6: `en_rd` is 1 in the cycle after any edge at which `sys_rst_n` is low, for every reset cause.
- R7: Writes to the enable bit are ignored while `sys_rst_n` is low and on the release edge, so `en_rd` reads 1 in the first cycle after release.
- R8: Outside reset, a write (`en_wr`=1) loads `en_wdata` into the enable bit, visible the next cycle.
- R9: `pin_pullup_en` and `pin_func_dbg` both follow the enable bit. On `pin_func_dbg`, 1 routes the pin to the debug engine and 0 routes it to the alternate function.
- R10: `bkgd_mode` changes only on the cycle after a qualifying release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block power-up reset, active low, asynchronous assert |
| sys_rst_n | input | 1 | Internal system reset, active low, synchronous to clk |
| por_cause | input | 1 | Current reset is a power-on reset |
| dbg_force_req | input | 1 | One-cycle request marking a debug-forced reset |
| pin_in | input | 1 | Raw level of the debug pin |
| en_wr | input | 1 | Software write strobe for the debug-pin enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| bkgd_mode | output | 1 | 1 = active background mode, 0 = normal mode |
| en_rd | output | 1 | Read-back of the enable bit |
| pin_pullup_en | output | 1 | Pin pull-up enable |
| pin_func_dbg | output | 1 | 1 = pin to debug engine, 0 = alternate function |
| rst_cause | output | 2 | Cause code of the latest reset |

## Verification
The assertions check on every cycle:
- the mode holds outside a qualifying release, and a qualifying release lands on the level given by the synchronized pin;
- the enable bit is forced to 1 during reset and still reads 1 just after release, and an accepted write takes effect;
- the cause code is frozen outside reset and is selected correctly when reset asserts.

Only the bench's scenarios can show the end-to-end effects. These are:
- an other-cause reset with the pin held low leaves normal mode in place;
- a request pulse inside reset is ignored;
- a late power-on indication upgrades the cause;
- a pin edge one cycle before release is not seen by the capture.

// File: rtl/dbgmode_pkg.sv
package dbgmode_pkg;

  typedef enum logic [1:0] {
    CAUSE_OTHER  = 2'd0,
    CAUSE_POR    = 2'd1,
    CAUSE_FORCED = 2'd2
  } rst_cause_e;

  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_BKGD   = 1'b1
  } run_mode_e;

  // Idle level of the pulled-up debug pin
  localparam logic PIN_IDLE = 1'b1;

endpackage

// File: rtl/dbgmode_sync.sv
module dbgmode_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sh_d = d;
    end else begin : g_chain
      assign sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/dbgmode_cause.sv
module dbgmode_cause
  import dbgmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst_n,
  input  logic       por_cause,
  input  logic       force_req,
  output rst_cause_e cause_o,
  output logic       release_o,
  output logic       qualify_o
);

  logic       prev_q, prev_d;
  logic       pend_q, pend_d;
  rst_cause_e cause_q, cause_d;
  logic       start_c;

  // Edge detection on the internal reset
  always_comb begin
    start_c   = prev_q & ~sys_rst_n;
    release_o = sys_rst_n & ~prev_q;
    prev_d    = sys_rst_n;
  end

  // Pending forced-reset request, collected outside reset only
  always_comb begin
    pend_d = pend_q;
    if (start_c)                     pend_d = 1'b0;
    else if (sys_rst_n && force_req) pend_d = 1'b1;
  end

  // Cause selection at reset entry, power-on may upgrade later
  always_comb begin
    cause_d = cause_q;
    if (start_c) begin
      if (por_cause)                   cause_d = CAUSE_POR;
      else if (pend_q || force_req)    cause_d = CAUSE_FORCED;
      else                             cause_d = CAUSE_OTHER;
    end else if (!sys_rst_n && por_cause) begin
      cause_d = CAUSE_POR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      cause_q <= CAUSE_POR;
    end else begin
      prev_q  <= prev_d;
      pend_q  <= pend_d;
      cause_q <= cause_d;
    end
  end

  assign cause_o   = cause_q;
  assign qualify_o = (cause_q == CAUSE_POR) || (cause_q == CAUSE_FORCED);

  // R2
  cause_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |=> $stable(cause_q));
  // R2
  cause_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_n && por_cause) |=> (cause_q == CAUSE_POR));
  // R2
  cause_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !por_cause && !pend_q && !force_req) |=> (cause_q == CAUSE_OTHER));

endmodule

// File: rtl/dbgmode_core.sv
module dbgmode_core
  import dbgmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sys_rst_n,
  input  logic      release_i,
  input  logic      qualify_i,
  input  logic      pin_s,
  input  logic      en_wr,
  input  logic      en_wdata,
  output run_mode_e mode_o,
  output logic      en_o
);

  run_mode_e mode_q, mode_d;
  logic      en_q, en_d;
  logic      cap_c;
  logic      wr_ok_c;

  always_comb begin
    cap_c   = release_i & qualify_i;
    wr_ok_c = sys_rst_n & ~release_i & en_wr;
  end

  // Mode capture on a qualifying reset release
  always_comb begin
    mode_d = mode_q;
    if (cap_c) mode_d = pin_s ? MODE_NORMAL : MODE_BKGD;
  end

  // Debug-pin enable bit
  always_comb begin
    en_d = en_q;
    if (!sys_rst_n)   en_d = 1'b1;
    else if (wr_ok_c) en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      en_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(release_i && qualify_i) |=> $stable(mode_q));
  // R3
  bkgd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && qualify_i && !pin_s) |=> (mode_q == MODE_BKGD));
  // R3
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && qualify_i && pin_s) |=> (mode_q == MODE_NORMAL));
  // R6
  en_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |=> en_q);
  // R7
  en_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> en_q);
  // R8
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && !release_i && en_wr) |=> (en_q == $past(en_wdata)));

endmodule

// File: rtl/dbg_pin_mode_ctl.sv
module dbg_pin_mode_ctl
  import dbgmode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst_n,
  input  logic       por_cause,
  input  logic       dbg_force_req,
  input  logic       pin_in,
  input  logic       en_wr,
  input  logic       en_wdata,
  output logic       bkgd_mode,
  output logic       en_rd,
  output logic       pin_pullup_en,
  output logic       pin_func_dbg,
  output logic [1:0] rst_cause
);

  logic       pin_s;
  logic       rel_w;
  logic       qual_w;
  rst_cause_e cause_w;
  run_mode_e  mode_w;
  logic       en_w;

  dbgmode_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  dbgmode_cause u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_n (sys_rst_n),
    .por_cause (por_cause),
    .force_req (dbg_force_req),
    .cause_o   (cause_w),
    .release_o (rel_w),
    .qualify_o (qual_w)
  );

  dbgmode_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_rst_n (sys_rst_n),
    .release_i (rel_w),
    .qualify_i (qual_w),
    .pin_s     (pin_s),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .mode_o    (mode_w),
    .en_o      (en_w)
  );

  assign bkgd_mode     = (mode_w == MODE_BKGD);
  assign en_rd         = en_w;
  assign pin_pullup_en = en_w;
  assign pin_func_dbg  = en_w;
  assign rst_cause     = cause_w;

  // R4
  other_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_w && (cause_w == CAUSE_OTHER)) |=> $stable(bkgd_mode));

endmodule

// File: tb/sim_dbg_pin_mode_ctl.sv
`timescale 1ns/1ps
module sim_dbg_pin_mode_ctl;

  logic       clk = 1'b0;
  logic       rst_n, sys_rst_n, por_cause, dbg_force_req, pin_in, en_wr, en_wdata;
  logic       bkgd_mode, en_rd, pin_pullup_en, pin_func_dbg;
  logic [1:0] rst_cause;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dbg_pin_mode_ctl u0 (
    .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n), .por_cause(por_cause),
    .dbg_force_req(dbg_force_req), .pin_in(pin_in), .en_wr(en_wr),
    .en_wdata(en_wdata), .bkgd_mode(bkgd_mode), .en_rd(en_rd),
    .pin_pullup_en(pin_pullup_en), .pin_func_dbg(pin_func_dbg),
    .rst_cause(rst_cause)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_mode, m_en, m_cause;
  bit m_pend, m_prev;
  bit pq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_en = 1; m_cause = 1; m_pend = 0; m_prev = 0;
      pq = '{1'b1, 1'b1};
    end else begin
      bit ps, rel, start;
      ps = pq[0];
      void'(pq.pop_front());
      pq.push_back(pin_in);
      rel   = sys_rst_n && !m_prev;
      start = !sys_rst_n && m_prev;
      if (rel && (m_cause == 1 || m_cause == 2)) m_mode = ps ? 0 : 1;
      if (!sys_rst_n) m_en = 1;
      else if (m_prev && en_wr) m_en = en_wdata;
      if (start) m_cause = por_cause ? 1 : ((m_pend || dbg_force_req) ? 2 : 0);
      else if (!sys_rst_n && por_cause) m_cause = 1;
      if (start) m_pend = 0;
      else if (sys_rst_n && dbg_force_req) m_pend = 1;
      m_prev = sys_rst_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 mode vs model", bkgd_mode, m_mode);
      chk("R6 enable vs model", en_rd, m_en);
      chk("R9 pullup vs model", pin_pullup_en, m_en);
      chk("R9 route vs model", pin_func_dbg, m_en);
      chk("R2 cause vs model", rst_cause, m_cause);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sys_rst_n = 0; por_cause = 1; dbg_force_req = 0;
    pin_in = 0; en_wr = 0; en_wdata = 0;
    tick(2);
    chk("R1 mode", bkgd_mode, 0);
    chk("R1 enable", en_rd, 1);
    chk("R1 pullup", pin_pullup_en, 1);
    chk("R1 route", pin_func_dbg, 1);
    chk("R1 cause", rst_cause, 1);
    rst_n = 1;
    tick(4);
    sys_rst_n = 1; por_cause = 0;
    tick(2);
    chk("R3 power-on low pin", bkgd_mode, 1);
    chk("R2 power-on cause", rst_cause, 1);

    // software takes the pin
    en_wr = 1; en_wdata = 0; tick(1); en_wr = 0; tick(1);
    chk("R8 write clears", en_rd, 0);
    chk("R9 pullup off", pin_pullup_en, 0);
    chk("R9 route alternate", pin_func_dbg, 0);

    // other reset with pin high
    pin_in = 1; tick(3);
    sys_rst_n = 0; tick(2);
    chk("R6 enable set in reset", en_rd, 1);
    tick(2); sys_rst_n = 1; tick(2);
    chk("R4 other keeps mode", bkgd_mode, 1);
    chk("R2 other cause", rst_cause, 0);

    // forced reset via early request, pin high
    dbg_force_req = 1; tick(1); dbg_force_req = 0; tick(2);
    sys_rst_n = 0; tick(4); sys_rst_n = 1; tick(2);
    chk("R3 forced high pin", bkgd_mode, 0);
    chk("R2 forced cause", rst_cause, 2);

    // other reset with pin low
    pin_in = 0; tick(3);
    sys_rst_n = 0; tick(4); sys_rst_n = 1; tick(2);
    chk("R4 other ignores low pin", bkgd_mode, 0);

    // request on the reset-entry cycle
    sys_rst_n = 0; dbg_force_req = 1; tick(1); dbg_force_req = 0;
    tick(3); sys_rst_n = 1; tick(2);
    chk("R3 forced low pin", bkgd_mode, 1);
    chk("R2 request at entry", rst_cause, 2);

    // request inside reset is ignored
    pin_in = 1; tick(3);
    sys_rst_n = 0; tick(2); dbg_force_req = 1; tick(1); dbg_force_req = 0;
    tick(2); sys_rst_n = 1; tick(2);
    chk("R2 request in reset ignored", rst_cause, 0);
    chk("R4 mode kept", bkgd_mode, 1);

    // power-on indication arrives mid-reset
    sys_rst_n = 0; tick(2); por_cause = 1; tick(1); por_cause = 0;
    tick(2); sys_rst_n = 1; tick(2);
    chk("R2 power-on upgrade", rst_cause, 1);
    chk("R3 power-on high pin", bkgd_mode, 0);

    // writes during reset and on the release edge
    en_wr = 1; en_wdata = 0; sys_rst_n = 0; tick(3);
    sys_rst_n = 1; tick(1);
    chk("R7 enable after release", en_rd, 1);
    tick(1);
    chk("R8 write after release", en_rd, 0);
    en_wr = 0;

    // late pin change is not seen
    pin_in = 0; tick(3);
    dbg_force_req = 1; tick(1); dbg_force_req = 0;
    sys_rst_n = 0; tick(3);
    pin_in = 1; tick(1);
    sys_rst_n = 1; tick(2);
    chk("R5 late pin edge unseen", bkgd_mode, 1);
    chk("R7 enable restored", en_rd, 1);

    tick(5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule